// File: doc/BRIEF.md
# Automatic remote loopback controller

This block watches the recovered receive bit stream for two programmable repeating patterns: an activation pattern and a release pattern. While the block is armed and idle, it looks for the activation pattern. It enters remote loopback once that pattern has stayed in sync for a set number of one-second ticks. Once in loopback, it looks only for the release pattern, and leaves when that pattern has persisted for the same number of ticks.

The automatic state is ORed with a manual loopback bit to form the effective loopback select. When loopback is active, a transmit-source select tells the transmit path to send the recovered receive data instead of the external transmit data.

Pattern detection works in any phase. The most recent received bits are compared against every rotation of the programmed pattern. The detector tolerates a limited number of mismatching bit positions within a fixed-length window of received bits.

Top module: `rlb_auto_ctrl`

## Requirements
- R1: The pattern is `{hi, lo}`, with `hi` in bits 15:8. Only the low `code_len+1` bits are used (1 to 16). Bit 0 is received first, and a stream that repeats the pattern is recognised whatever its starting phase.
- R2: Received bits are grouped into windows of WIN_BITS bits. A bit position mismatches when the newest `code_len+1` bits are not a rotation of the pattern. At each window end, sync is set if the mismatches in that window are at most ERR_LIMIT, and cleared otherwise.
- R3: While armed and idle, HOLD_TICKS ticks received with activation-pattern sync move the block into loopback, and `auto_flag` rises on the last of these ticks.
- R4: Loss of sync clears the tick count, so a pattern that is interrupted needs a full HOLD_TICKS ticks again after it resumes.
- R5: While in loopback, HOLD_TICKS ticks received with release-pattern sync return the block to idle and clear `auto_flag`.
- R6: The release pattern has no effect while idle, and the activation pattern has no effect while in loopback.
- R7: While `auto_en` is low, the block is held idle with `auto_flag` low and its counters cleared. Tick counting restarts from zero after `auto_en` rises again.
- R8: `rlb_sel` is high whenever `man_rlb` is high or the block is in automatic loopback.
- R9: `tx_src_sel` is 1 (send recovered receive data) whenever `rlb_sel` is high, and 0 (send external data) otherwise.
- R10: After reset, `rlb_sel`, `auto_flag` and `tx_src_sel` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Qualifies `rx_bit` for this cycle |
| rx_bit | input | 1 | Recovered receive data bit |
| up_code_hi | input | 8 | Activation pattern bits 15:8 |
| up_code_lo | input | 8 | Activation pattern bits 7:0 |
| dn_code_hi | input | 8 | Release pattern bits 15:8 |
| dn_code_lo | input | 8 | Release pattern bits 7:0 |
| code_len | input | 4 | Pattern length minus one |
| auto_en | input | 1 | Arms automatic loopback; low forces idle |
| man_rlb | input | 1 | Manual remote loopback |
| sec_tick | input | 1 | One-cycle pulse once per second |
| rlb_sel | output | 1 | Effective remote-loopback select |
| auto_flag | output | 1 | High while in automatic loopback |
| tx_src_sel | output | 1 | 1 selects recovered data for transmit |

## Verification
The bench builds the block with a 32-bit window and an error limit of 2, and keeps five ticks. Ticks are issued by the bench itself rather than by a real one-second timer, so full entry and exit sequences take a few hundred cycles. This makes it practical to sweep every pattern length from 1 to 16. The short window lets the bench place error bits exactly at the tolerance limit and just past it. It also lets the bench check interrupted patterns and enable toggling within a small run.

// File: rtl/rlb_auto_ctrl.sv
module rlb_auto_ctrl #(
  parameter int CODE_W     = 16,
  parameter int WIN_BITS   = 1000,
  parameter int ERR_LIMIT  = 15,
  parameter int HOLD_TICKS = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rx_en,
  input  logic                          rx_bit,
  input  logic [CODE_W/2-1:0]           up_code_hi,
  input  logic [CODE_W/2-1:0]           up_code_lo,
  input  logic [CODE_W/2-1:0]           dn_code_hi,
  input  logic [CODE_W/2-1:0]           dn_code_lo,
  input  logic [$clog2(CODE_W)-1:0]     code_len,
  input  logic                          auto_en,
  input  logic                          man_rlb,
  input  logic                          sec_tick,
  output logic                          rlb_sel,
  output logic                          auto_flag,
  output logic                          tx_src_sel
);
  localparam int LW = $clog2(CODE_W);
  localparam int WW = $clog2(WIN_BITS + 1);
  localparam int TW = $clog2(HOLD_TICKS + 1);

  logic              in_loop, sync;
  logic [CODE_W-1:0] hist, hist_nx, code, mask, win, hit;
  logic [2*CODE_W-1:0] dbl;
  logic [LW:0]       len, sh;
  logic [WW-1:0]     bitcnt, errcnt, err_nx;
  logic [TW-1:0]     tcnt;
  logic              mis, flip;

  assign len     = {1'b0, code_len} + 1'b1;
  assign sh      = (LW+1)'(CODE_W) - len;
  assign mask    = ~({CODE_W{1'b1}} << len);
  assign code    = (in_loop ? {dn_code_hi, dn_code_lo} : {up_code_hi, up_code_lo}) & mask;
  assign dbl     = {{CODE_W{1'b0}}, code} | ({{CODE_W{1'b0}}, code} << len);
  assign hist_nx = {rx_bit, hist[CODE_W-1:1]};
  assign win     = hist_nx >> sh;

  for (genvar r = 0; r < CODE_W; r++) begin : g_rot
    assign hit[r] = ((LW+1)'(r) < len) && (((win ^ dbl[r +: CODE_W]) & mask) == '0);
  end

  assign mis    = ~|hit;
  assign err_nx = errcnt + WW'(mis);
  assign flip   = sec_tick && sync && (tcnt == TW'(HOLD_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist    <= '0;
      in_loop <= 1'b0;
      sync    <= 1'b0;
      bitcnt  <= '0;
      errcnt  <= '0;
      tcnt    <= '0;
    end else begin
      if (rx_en) hist <= hist_nx;
      if (!auto_en) begin
        in_loop <= 1'b0;
        sync    <= 1'b0;
        bitcnt  <= '0;
        errcnt  <= '0;
        tcnt    <= '0;
      end else if (flip) begin
        in_loop <= !in_loop;
        sync    <= 1'b0;
        bitcnt  <= '0;
        errcnt  <= '0;
        tcnt    <= '0;
      end else begin
        if (rx_en) begin
          if (bitcnt == WW'(WIN_BITS - 1)) begin
            sync   <= err_nx <= WW'(ERR_LIMIT);
            bitcnt <= '0;
            errcnt <= '0;
          end else begin
            bitcnt <= bitcnt + 1'b1;
            errcnt <= err_nx;
          end
        end
        if (!sync)         tcnt <= '0;
        else if (sec_tick) tcnt <= tcnt + 1'b1;
      end
    end
  end

  assign auto_flag  = in_loop;
  assign rlb_sel    = in_loop | man_rlb;
  assign tx_src_sel = rlb_sel;
endmodule

// File: rtl/rlb_auto_ctrl_chk.sv
module rlb_auto_ctrl_chk #(
  parameter int HOLD_TICKS = 5,
  parameter int TW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          auto_en,
  input logic          man_rlb,
  input logic          sec_tick,
  input logic          rlb_sel,
  input logic          auto_flag,
  input logic          tx_src_sel,
  input logic [TW-1:0] tcnt
);
  AST_ENTRY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(auto_flag) |-> $past(sec_tick) && $past(auto_en)); // R3
  AST_EXIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(auto_flag) |-> $past(sec_tick) || !$past(auto_en)); // R5
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> !auto_flag); // R7
  AST_MANUAL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    man_rlb |-> rlb_sel); // R8
  AST_TX_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rlb_sel |-> tx_src_sel); // R9
  AST_COUNT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (tcnt > $past(tcnt)) |-> $past(sec_tick)); // R4
  AST_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && auto_en) |=> $stable(auto_flag)); // R6
  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt < TW'(HOLD_TICKS)); // R4
endmodule

bind rlb_auto_ctrl rlb_auto_ctrl_chk #(.HOLD_TICKS(HOLD_TICKS), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .man_rlb(man_rlb),
  .sec_tick(sec_tick), .rlb_sel(rlb_sel), .auto_flag(auto_flag),
  .tx_src_sel(tx_src_sel), .tcnt(tcnt)
);

// File: tb/rlb_auto_ctrl_test.sv
module rlb_auto_ctrl_test;
  localparam int WIN = 32;
  localparam int LIM = 2;
  localparam int HOLD = 5;

  logic clk = 0, rst_n = 0, rx_en = 0, rx_bit = 0;
  logic [7:0] up_code_hi = 0, up_code_lo = 0, dn_code_hi = 0, dn_code_lo = 0;
  logic [3:0] code_len = 0;
  logic auto_en = 0, man_rlb = 0, sec_tick = 0;
  logic rlb_sel, auto_flag, tx_src_sel;

  int checks = 0, errors = 0;
  int ph = 0;
  int cur_len = 1;
  logic [15:0] cur_code = 16'h0001;
  int err_every = 0;

  rlb_auto_ctrl #(.CODE_W(16), .WIN_BITS(WIN), .ERR_LIMIT(LIM), .HOLD_TICKS(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_bit(rx_bit),
    .up_code_hi(up_code_hi), .up_code_lo(up_code_lo),
    .dn_code_hi(dn_code_hi), .dn_code_lo(dn_code_lo),
    .code_len(code_len), .auto_en(auto_en), .man_rlb(man_rlb), .sec_tick(sec_tick),
    .rlb_sel(rlb_sel), .auto_flag(auto_flag), .tx_src_sel(tx_src_sel));

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic tick);
    logic b;
    b = cur_code[ph % cur_len];
    if (err_every > 0 && (ph % err_every) == 0) b = 1'b0;
    ph++;
    @(negedge clk);
    rx_bit = b; rx_en = 1'b1; sec_tick = tick;
    @(posedge clk);
    #2 rx_en = 1'b0; sec_tick = 1'b0;
  endtask

  task automatic bits(input int n);
    for (int i = 0; i < n; i++) step(1'b0);
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin bits(4); step(1'b1); end
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 0; auto_en = 0; man_rlb = 0; err_every = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
  endtask

  task automatic set_up(input int len, input logic [15:0] up);
    code_len = 4'(len - 1);
    up_code_hi = up[15:8]; up_code_lo = up[7:0];
    dn_code_hi = 8'h00; dn_code_lo = 8'h00;
    cur_len = len; cur_code = up;
  endtask

  task automatic use_down;
    cur_code = 16'h0000;
  endtask

  task automatic enter_loop(input string req);
    bits(3 * WIN);
    tick_n(HOLD - 1);
    chk({req, " before last tick"}, auto_flag, 1'b0);
    tick_n(1);
    chk({req, " flag after last tick"}, auto_flag, 1'b1);
    chk({req, " rlb_sel"}, rlb_sel, 1'b1);
  endtask

  initial begin
    int wd = 0;
    while (wd < 100000) begin @(posedge clk); wd++; end
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset;
    chk("R10 rlb_sel", rlb_sel, 1'b0);
    chk("R10 auto_flag", auto_flag, 1'b0);
    chk("R10 tx_src_sel", tx_src_sel, 1'b0);

    // R1 R3 R5 R6 R9 sweep over every length
    for (int len = 1; len <= 16; len++) begin
      logic [15:0] up;
      up = (16'hA6E9 ^ 16'(len * 16'h1357)) | 16'h0001;
      do_reset;
      ph = len * 3;
      set_up(len, up);
      auto_en = 1;
      enter_loop($sformatf("R1 R3 len=%0d", len));
      chk("R9 tx_src in loop", tx_src_sel, 1'b1);
      bits(3 * WIN);
      tick_n(HOLD + 1);
      chk($sformatf("R6 up code in loop len=%0d", len), auto_flag, 1'b1);
      use_down;
      bits(3 * WIN);
      tick_n(HOLD - 1);
      chk($sformatf("R5 before last tick len=%0d", len), auto_flag, 1'b1);
      tick_n(1);
      chk($sformatf("R5 exit len=%0d", len), auto_flag, 1'b0);
      chk("R9 tx_src idle", tx_src_sel, 1'b0);
      bits(3 * WIN);
      tick_n(HOLD + 1);
      chk($sformatf("R6 down code idle len=%0d", len), auto_flag, 1'b0);
    end

    // R4 interrupted pattern
    do_reset;
    set_up(5, 16'h0013);
    auto_en = 1;
    bits(3 * WIN);
    tick_n(3);
    cur_code = 16'h0000;
    bits(2 * WIN);
    cur_code = 16'h0013;
    bits(3 * WIN);
    tick_n(HOLD - 1);
    chk("R4 count restarted", auto_flag, 1'b0);
    tick_n(1);
    chk("R4 entry after full hold", auto_flag, 1'b1);

    // R2 error tolerance at and past the limit
    do_reset;
    set_up(1, 16'h0001);
    auto_en = 1;
    err_every = 16;
    bits(4 * WIN);
    tick_n(HOLD);
    chk("R2 two errors per window tolerated", auto_flag, 1'b1);
    do_reset;
    set_up(1, 16'h0001);
    auto_en = 1;
    err_every = 10;
    bits(4 * WIN);
    tick_n(HOLD + 1);
    chk("R2 three errors per window rejected", auto_flag, 1'b0);
    err_every = 0;

    // R7 enable low clears and blocks
    do_reset;
    set_up(3, 16'h0006 | 16'h0001);
    auto_en = 1;
    enter_loop("R7 setup");
    @(negedge clk); auto_en = 0;
    @(posedge clk); #2;
    chk("R7 flag cleared by enable low", auto_flag, 1'b0);
    chk("R7 rlb_sel cleared", rlb_sel, 1'b0);
    bits(3 * WIN);
    tick_n(HOLD + 1);
    chk("R7 no entry while disabled", auto_flag, 1'b0);
    auto_en = 1;
    tick_n(HOLD);
    chk("R7 count restarts after enable", auto_flag, 1'b0);

    // R8 manual OR
    do_reset;
    set_up(3, 16'h0007);
    @(negedge clk); man_rlb = 1; #1;
    chk("R8 manual in idle rlb_sel", rlb_sel, 1'b1);
    chk("R8 manual leaves flag low", auto_flag, 1'b0);
    chk("R9 tx_src with manual", tx_src_sel, 1'b1);
    man_rlb = 0; #1;
    chk("R8 manual off", rlb_sel, 1'b0);
    auto_en = 1;
    enter_loop("R8 auto");
    chk("R8 auto alone drives rlb_sel", rlb_sel, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule